// File: doc/BRIEF.md
# Write-Word Command Parser

This block sits behind the bit-synchronisation stage of a contactless transponder's receive path. Once the reader and the tag are in step, each decoded downlink bit arrives as a one-cycle `bit_valid` pulse carrying `bit_value`. The parser groups the first four bits into a command. The command is three code bits, most significant first, followed by an even-parity bit. Read and authentication commands are reported to the rest of the chip. A write command makes the parser collect a 30-bit frame carrying a word address and a 16-bit data word, both protected by parity.

The frame is checked for row parity, column parity and the trailing zero. The parser also checks the current lock bits and the legality of the address. It then asks the response sequencer for an acknowledge, a no-acknowledge or a silent abort. When a write is accepted, the parser gives a one-cycle write strobe together with the first acknowledge. It then times the programming interval, waits until memory is no longer busy, and requests a second acknowledge before it looks for the next command.

The parser has six states. ST_CMD gathers command bits and moves to ST_CMD_CHK on the fourth bit. ST_CMD_CHK reports a good command or requests an abort, and goes to ST_FRAME for a write or back to ST_CMD otherwise. ST_FRAME gathers the 30 frame bits and moves to ST_FRAME_CHK on the last one. ST_FRAME_CHK requests an abort or a no-acknowledge and returns to ST_CMD, or it accepts the write and goes to ST_PROG. ST_PROG stays until the timer has run out with memory idle, then moves to ST_DONE. ST_DONE requests the second acknowledge and returns to ST_CMD.

Top module: `wordcmd_parser`

## Requirements
- R1: A command is four bits received most significant first: code c2 c1 c0, then a parity bit that makes the count of ones even. The codes are 001 identifier read, 010 user-memory read, 011 authentication and 101 write. A good command raises `cmd_valid` for one cycle, with the code on `cmd_out`, in the cycle after the clock edge that takes the fourth bit.
- R2: A command with odd parity, or with any code outside the four known codes, raises `abort_req` for one cycle in that same cycle with `cmd_valid` low. The parser then takes the next bit as the start of a new command.
- R3: After a write command the parser takes 30 bits in this order: A3..A0 and the address parity; four rows of a data nibble (D15..D12 first) each followed by its even parity; column parities PC3..PC0, where PCk covers data bit k of every nibble; and a trailing bit.
- R4: A trailing bit of 1 raises `abort_req`, with no `nak_req` and no `ack_req`, whatever the other checks find.
- R5: With a zero trailing bit, an odd address row, an odd data row or an odd data column raises `nak_req` for one cycle.
- R6: A write is refused with `nak_req` unless `lock_hi`=1 and `lock_lo`=0.
- R7: A write to address 2, 3 or any address above 9 is refused with `nak_req`. Addresses 0 and 9 are accepted.
- R8: An accepted write raises `ack_req` and `wr_strobe` together for one cycle, in the cycle after the edge that takes the trailing bit. `wr_addr` and `wr_data` hold the received values from then until the second acknowledge.
- R9: With `mem_busy` low, the second `ack_req` comes PROG_CYCLES+1 cycles after the first. If `mem_busy` is still high at that point, the second acknowledge comes in the cycle after the first edge that samples `mem_busy` low.
- R10: Bits that arrive while a write is being programmed are ignored. After the second acknowledge the parser decodes a fresh command.
- R11: After reset all request and strobe outputs are low. `ack_req`, `nak_req` and `abort_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | One-cycle pulse per received bit |
| bit_value | input | 1 | Value of the received bit |
| lock_hi | input | 1 | Upper lock bit (must be 1 to write) |
| lock_lo | input | 1 | Lower lock bit (must be 0 to write) |
| mem_busy | input | 1 | Memory still programming |
| cmd_valid | output | 1 | Good command decoded |
| cmd_out | output | 3 | Decoded command code |
| wr_addr | output | 4 | Write word address |
| wr_data | output | 16 | Write data word |
| wr_strobe | output | 1 | Start programming |
| ack_req | output | 1 | Request acknowledge pattern |
| nak_req | output | 1 | Request no-acknowledge pattern |
| abort_req | output | 1 | Silent return to standby |

## Verification
Every legal command code is sent with its correct parity, and so are codes with flipped parity and the unused code patterns. This separates a parity check from a code-table check. Write frames are sent with single faults that each trip exactly one check: a flipped row parity bit alone tests the row check, and a data bit flipped together with its row parity tests the column check. Lock-bit combinations and the protected, boundary and out-of-range addresses are also sent. A frame with a bad trailing bit and bad lock bits shows that the abort takes precedence. Accepted writes are timed with memory idle and with memory held busy past the timer, and stray bits are sent during programming to show that they are ignored.

// File: rtl/wcp_pkg.sv
package wcp_pkg;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_CMD_CHK,
        ST_FRAME,
        ST_FRAME_CHK,
        ST_PROG,
        ST_DONE
    } wcp_state_e;

    localparam logic [2:0] CODE_IDENT = 3'b001;
    localparam logic [2:0] CODE_UMEM  = 3'b010;
    localparam logic [2:0] CODE_AUTH  = 3'b011;
    localparam logic [2:0] CODE_WRITE = 3'b101;

    function automatic logic code_known(input logic [2:0] c);
        return (c == CODE_IDENT) || (c == CODE_UMEM) ||
               (c == CODE_AUTH)  || (c == CODE_WRITE);
    endfunction

endpackage

// File: rtl/wcp_shifter.sv
module wcp_shifter #(
    parameter int WIDTH = 30,
    localparam int CW   = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [WIDTH-1:0] q,
    output logic [CW-1:0]    cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= '0;
            cnt <= '0;
        end else if (clr) begin
            q   <= '0;
            cnt <= '0;
        end else if (en) begin
            q   <= {q[WIDTH-2:0], din};
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wcp_frame_check.sv
module wcp_frame_check #(
    parameter int NIB_W     = 4,
    parameter int DATA_NIBS = 4,
    localparam int ROW_W    = NIB_W + 1,
    localparam int FRAME_W  = ROW_W * (DATA_NIBS + 2),
    localparam int DATA_W   = NIB_W * DATA_NIBS
) (
    input  logic [FRAME_W-1:0] frame,
    output logic [NIB_W-1:0]   addr,
    output logic [DATA_W-1:0]  data,
    output logic               trail_bad,
    output logic               addr_bad,
    output logic               row_bad,
    output logic               col_bad
);
    logic [DATA_NIBS-1:0] row_err;
    logic [NIB_W-1:0]     col_acc;

    assign addr      = frame[FRAME_W-1 -: NIB_W];
    assign addr_bad  = ^frame[FRAME_W-1 -: ROW_W];
    assign trail_bad = frame[0];

    genvar r;
    generate
        for (r = 0; r < DATA_NIBS; r++) begin : g_row
            localparam int TOP = FRAME_W - 1 - ROW_W * (r + 1);
            assign row_err[r] = ^frame[TOP -: ROW_W];
            assign data[DATA_W-1-NIB_W*r -: NIB_W] = frame[TOP -: NIB_W];
        end
    endgenerate

    always_comb begin
        col_acc = frame[NIB_W:1];
        for (int k = 0; k < DATA_NIBS; k++) begin
            col_acc = col_acc ^ data[NIB_W*k +: NIB_W];
        end
    end

    assign row_bad = |row_err;
    assign col_bad = |col_acc;
endmodule

// File: rtl/wcp_prog_timer.sv
module wcp_prog_timer #(
    parameter int CYCLES = 3072,
    localparam int TW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam logic [TW-1:0] LAST = TW'(CYCLES - 1);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/wordcmd_parser.sv
module wordcmd_parser
    import wcp_pkg::*;
#(
    parameter int NIB_W       = 4,
    parameter int DATA_NIBS   = 4,
    parameter int MAX_ADDR    = 9,
    parameter int PROT_LO     = 2,
    parameter int PROT_HI     = 3,
    parameter int PROG_CYCLES = 3072,
    localparam int DATA_W     = NIB_W * DATA_NIBS,
    localparam int FRAME_W    = (NIB_W + 1) * (DATA_NIBS + 2),
    localparam int CMD_W      = 4,
    localparam int CW         = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_value,
    input  logic              lock_hi,
    input  logic              lock_lo,
    input  logic              mem_busy,
    output logic              cmd_valid,
    output logic [2:0]        cmd_out,
    output logic [NIB_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_strobe,
    output logic              ack_req,
    output logic              nak_req,
    output logic              abort_req
);
    localparam logic [CW-1:0] LAST_CMD   = CW'(CMD_W - 1);
    localparam logic [CW-1:0] LAST_FRAME = CW'(FRAME_W - 1);

    wcp_state_e state, state_nx;

    logic [FRAME_W-1:0] sr;
    logic [CW-1:0]      cnt;
    logic               shift_en, shift_clr;
    logic               trail_bad, addr_bad, row_bad, col_bad;
    logic               prog_done;
    logic               cmd_ok, addr_legal, lock_open, frame_ok;

    assign shift_en  = bit_valid && (state == ST_CMD || state == ST_FRAME);
    assign shift_clr = (state == ST_CMD_CHK) || (state == ST_DONE) ||
                       (state == ST_FRAME_CHK && !frame_ok);

    wcp_shifter #(.WIDTH(FRAME_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (shift_clr),
        .en    (shift_en),
        .din   (bit_value),
        .q     (sr),
        .cnt   (cnt)
    );

    wcp_frame_check #(.NIB_W(NIB_W), .DATA_NIBS(DATA_NIBS)) u_chk (
        .frame     (sr),
        .addr      (wr_addr),
        .data      (wr_data),
        .trail_bad (trail_bad),
        .addr_bad  (addr_bad),
        .row_bad   (row_bad),
        .col_bad   (col_bad)
    );

    wcp_prog_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_PROG),
        .done  (prog_done)
    );

    assign cmd_out    = sr[3:1];
    assign cmd_ok     = !(^sr[3:0]) && code_known(sr[3:1]);
    assign addr_legal = (int'(wr_addr) <= MAX_ADDR) &&
                        (int'(wr_addr) != PROT_LO) && (int'(wr_addr) != PROT_HI);
    assign lock_open  = lock_hi && !lock_lo;
    assign frame_ok   = !trail_bad && !addr_bad && !row_bad && !col_bad &&
                        addr_legal && lock_open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CMD;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CMD:       if (shift_en && cnt == LAST_CMD) state_nx = ST_CMD_CHK;
            ST_CMD_CHK:   state_nx = (cmd_ok && sr[3:1] == CODE_WRITE) ? ST_FRAME : ST_CMD;
            ST_FRAME:     if (shift_en && cnt == LAST_FRAME) state_nx = ST_FRAME_CHK;
            ST_FRAME_CHK: state_nx = frame_ok ? ST_PROG : ST_CMD;
            ST_PROG:      if (prog_done && !mem_busy) state_nx = ST_DONE;
            ST_DONE:      state_nx = ST_CMD;
            default:      state_nx = ST_CMD;
        endcase
    end

    always_comb begin
        cmd_valid = 1'b0;
        wr_strobe = 1'b0;
        ack_req   = 1'b0;
        nak_req   = 1'b0;
        abort_req = 1'b0;
        unique case (state)
            ST_CMD_CHK: begin
                cmd_valid = cmd_ok;
                abort_req = !cmd_ok;
            end
            ST_FRAME_CHK: begin
                if (trail_bad) begin
                    abort_req = 1'b1;
                end else if (frame_ok) begin
                    ack_req   = 1'b1;
                    wr_strobe = 1'b1;
                end else begin
                    nak_req   = 1'b1;
                end
            end
            ST_DONE:  ack_req = 1'b1;
            ST_CMD, ST_FRAME, ST_PROG: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/wcp_checker.sv
module wcp_checker #(
    parameter int NIB_W    = 4,
    parameter int MAX_ADDR = 9,
    parameter int PROT_LO  = 2,
    parameter int PROT_HI  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lock_hi,
    input logic             lock_lo,
    input logic             mem_busy,
    input logic             cmd_valid,
    input logic [2:0]       cmd_out,
    input logic [NIB_W-1:0] wr_addr,
    input logic             wr_strobe,
    input logic             ack_req,
    input logic             nak_req,
    input logic             abort_req
);
    assert_known_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_out == 3'b001 || cmd_out == 3'b010 ||
                       cmd_out == 3'b011 || cmd_out == 3'b101));

    assert_abort_not_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> !cmd_valid);

    assert_lock_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> (lock_hi && !lock_lo));

    assert_addr_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> ((int'(wr_addr) <= MAX_ADDR) &&
                       int'(wr_addr) != PROT_LO && int'(wr_addr) != PROT_HI));

    assert_strobe_with_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> ack_req);

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe && !ack_req);

    assert_addr_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !wr_strobe) |-> $stable(wr_addr));

    assert_ack2_after_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !wr_strobe) |-> !$past(mem_busy));

    assert_req_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_req, nak_req, abort_req}));
endmodule

bind wordcmd_parser wcp_checker #(
    .NIB_W    (NIB_W),
    .MAX_ADDR (MAX_ADDR),
    .PROT_LO  (PROT_LO),
    .PROT_HI  (PROT_HI)
) u_wcp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_hi   (lock_hi),
    .lock_lo   (lock_lo),
    .mem_busy  (mem_busy),
    .cmd_valid (cmd_valid),
    .cmd_out   (cmd_out),
    .wr_addr   (wr_addr),
    .wr_strobe (wr_strobe),
    .ack_req   (ack_req),
    .nak_req   (nak_req),
    .abort_req (abort_req)
);

// File: tb/wordcmd_parser_test.sv
module wordcmd_parser_test;
    localparam int PROG = 3072;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_value = 1'b0;
    logic        lock_hi = 1'b1;
    logic        lock_lo = 1'b0;
    logic        mem_busy = 1'b0;
    logic        cmd_valid;
    logic [2:0]  cmd_out;
    logic [3:0]  wr_addr;
    logic [15:0] wr_data;
    logic        wr_strobe, ack_req, nak_req, abort_req;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    wordcmd_parser #(.PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_value(bit_value),
        .lock_hi(lock_hi), .lock_lo(lock_lo), .mem_busy(mem_busy),
        .cmd_valid(cmd_valid), .cmd_out(cmd_out), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_strobe(wr_strobe), .ack_req(ack_req),
        .nak_req(nak_req), .abort_req(abort_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] reqs();
        return {cmd_valid, wr_strobe, ack_req, nak_req, abort_req};
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_valid = 1'b1;
        bit_value = b;
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic send_cmd(input logic [3:0] c);
        for (int i = 3; i >= 0; i--) send_bit(c[i]);
    endtask

    function automatic logic [29:0] build(input logic [3:0] a, input logic [15:0] d);
        logic [3:0] pc;
        pc = d[15:12] ^ d[11:8] ^ d[7:4] ^ d[3:0];
        return {a, ^a, d[15:12], ^d[15:12], d[11:8], ^d[11:8],
                d[7:4], ^d[7:4], d[3:0], ^d[3:0], pc, 1'b0};
    endfunction

    // Write command then frame; returns at the negedge where the verdict shows.
    task automatic send_write(input logic [3:0] a, input logic [15:0] d, input logic [29:0] flip);
        logic [29:0] f;
        send_cmd(4'b1010);
        chk("R1 write cmd", {cmd_valid, cmd_out}, {1'b1, 3'b101});
        f = build(a, d) ^ flip;
        for (int i = 29; i >= 0; i--) send_bit(f[i]);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 reset outputs", 32'(reqs()), 32'h0);
    endtask

    task automatic t_read_cmds();
        send_cmd(4'b0011);
        chk("R1 ident read", {cmd_valid, abort_req, cmd_out}, {2'b10, 3'b001});
        idle(1);
        chk("R1 pulse one cycle", 32'(cmd_valid), 0);
        send_cmd(4'b0101);
        chk("R1 user read", {cmd_valid, abort_req, cmd_out}, {2'b10, 3'b010});
        idle(1);
        send_cmd(4'b0110);
        chk("R1 auth", {cmd_valid, abort_req, cmd_out}, {2'b10, 3'b011});
        idle(1);
    endtask

    task automatic t_bad_cmds();
        send_cmd(4'b0010);
        chk("R2 bad parity", 32'(reqs()), 32'b00001);
        idle(1);
        send_cmd(4'b1001);
        chk("R2 unknown code", 32'(reqs()), 32'b00001);
        idle(1);
        send_cmd(4'b1011);
        chk("R2 write code odd parity", 32'(reqs()), 32'b00001);
        idle(1);
        send_cmd(4'b0000);
        chk("R2 zero code", 32'(reqs()), 32'b00001);
        idle(1);
        send_cmd(4'b0101);
        chk("R2 recovers", {cmd_valid, cmd_out}, {1'b1, 3'b010});
        idle(1);
    endtask

    task automatic accept_and_time(input logic [3:0] a, input logic [15:0] d, input string tag);
        int ack_at;
        send_write(a, d, 30'h0);
        chk({tag, " accept"}, 32'(reqs()), 32'b01100);
        chk({tag, " addr"}, 32'(wr_addr), 32'(a));
        chk({tag, " data"}, 32'(wr_data), 32'(d));
        ack_at = -1;
        for (int n = 1; n <= PROG + 1; n++) begin
            @(negedge clk);
            bit_valid = (n < 20) && (n % 2 == 1);
            bit_value = 1'b1;
            if (n == 200) chk("R8 data held", {wr_addr, wr_data}, {a, d});
            if (ack_req && ack_at < 0) ack_at = n;
            if (nak_req || abort_req || cmd_valid) ack_at = -2;
        end
        bit_valid = 1'b0;
        chk({tag, " R9 second ack delay"}, 32'(ack_at), 32'(PROG + 1));
        idle(1);
    endtask

    task automatic t_write_ok();
        accept_and_time(4'd5, 16'hA5C3, "R3 R8");
        send_cmd(4'b0101);
        chk("R10 fresh command after write", {cmd_valid, cmd_out}, {1'b1, 3'b010});
        idle(1);
    endtask

    task automatic t_trailing();
        lock_hi = 1'b0;
        send_write(4'd5, 16'h1234, 30'h1);
        chk("R4 trailing abort beats nak", 32'(reqs()), 32'b00001);
        lock_hi = 1'b1;
        idle(1);
    endtask

    task automatic t_parity();
        send_write(4'd4, 16'h0F0F, 30'h1 << 20);
        chk("R5 data row parity", 32'(reqs()), 32'b00010);
        idle(1);
        send_write(4'd4, 16'h0F0F, (30'h1 << 24) | (30'h1 << 20));
        chk("R5 column parity", 32'(reqs()), 32'b00010);
        idle(1);
        send_write(4'd4, 16'h0F0F, 30'h1 << 3);
        chk("R5 column parity bit", 32'(reqs()), 32'b00010);
        idle(1);
        send_write(4'd4, 16'h0F0F, 30'h1 << 25);
        chk("R5 address parity", 32'(reqs()), 32'b00010);
        idle(1);
    endtask

    task automatic t_lock();
        logic [1:0] lk [3] = '{2'b11, 2'b00, 2'b01};
        foreach (lk[i]) begin
            {lock_hi, lock_lo} = lk[i];
            send_write(4'd6, 16'hBEEF, 30'h0);
            chk("R6 lock refused", 32'(reqs()), 32'b00010);
            idle(1);
        end
        {lock_hi, lock_lo} = 2'b10;
    endtask

    task automatic t_addr();
        logic [3:0] bad [4] = '{4'd2, 4'd3, 4'd10, 4'd15};
        foreach (bad[i]) begin
            send_write(bad[i], 16'h5555, 30'h0);
            chk("R7 address refused", 32'(reqs()), 32'b00010);
            idle(1);
        end
        accept_and_time(4'd0, 16'hFFFF, "R7 addr 0");
        accept_and_time(4'd9, 16'h0001, "R7 addr 9");
    endtask

    task automatic t_busy();
        int early;
        mem_busy = 1'b1;
        send_write(4'd7, 16'h8421, 30'h0);
        chk("R9 busy accept", 32'(reqs()), 32'b01100);
        early = 0;
        for (int n = 1; n <= PROG + 900; n++) begin
            @(negedge clk);
            if (ack_req) early++;
        end
        chk("R9 no ack while busy", 32'(early), 0);
        mem_busy = 1'b0;
        @(negedge clk);
        chk("R9 ack after busy drops", 32'(ack_req), 1);
        idle(1);
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_read_cmds();
        t_bad_cmds();
        t_write_ok();
        t_trailing();
        t_parity();
        t_lock();
        t_addr();
        t_busy();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule